// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Critical-Byte-First Line Fill

This block sits between a processor and byte-addressed main memory and serves reads only. A request address is split into three fields. The top bits are a tag. The middle bits pick exactly one cache line, so memory block number j can only live in line j modulo the line count. The bottom bits pick a byte inside the 4-byte line. When the indexed line is valid and its stored tag equals the address tag, the cache answers from its own storage and memory sees no traffic.

On a miss the cache issues one block fetch. The fetch address is the request address with its byte-offset bits forced to zero, and a separate field names the byte the processor is waiting for. Memory returns the line one byte per beat. The returned order starts at that byte and wraps around the line, so an offset of 2 gives the order 2, 3, 0, 1. The first beat is passed to the processor as soon as it arrives, while the other beats are still being written. No new request is taken until the whole line, its tag and its valid bit are written.

With the default parameters the address is 24 bits and the index is 8 bits (256 lines). Setting the index width to 14 gives the 16K-line layout with an 8-bit tag.

Top module: `dm_cache`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req_valid are both 0.
- R2: The line index is req_addr[IDX_W+1:2], the byte offset is req_addr[1:0] and the tag is the bits above the index. Two addresses with the same index but different tags compete for one line.
- R3: Every valid bit is cleared by reset. The first access to any line after reset is a miss.
- R4: On a hit, the cache raises rsp_valid in the cycle after acceptance, with the stored byte on rsp_data, and mem_req_valid stays 0.
- R5: On a miss, the cache raises mem_req_valid for exactly one cycle, in the cycle after acceptance. mem_req_addr equals req_addr with bits [1:0] cleared.
- R6: On a miss, mem_req_first equals req_addr[1:0]. Memory returns the beats in the order first, first+1, and so on, modulo 4, and each byte is stored at that offset.
- R7: On a miss, rsp_valid rises in the cycle after the first beat is accepted, carrying that beat's byte. This happens before any later beat is taken.
- R8: req_ready stays 0 from a miss until the last beat has been accepted. It returns to 1 in the cycle after the last beat.
- R9: After a fill, a request to any of the four bytes of that line hits and returns the memory byte at that address. A later fill of a conflicting block evicts the line, so the next access to the old block misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Read byte is valid for one cycle |
| rsp_data | output | 8 | Read byte |
| mem_req_valid | output | 1 | One-cycle block fetch request |
| mem_req_addr | output | ADDR_W | Block-aligned fetch address |
| mem_req_first | output | OFF_W | Offset of the byte to be returned first |
| mem_rsp_valid | input | 1 | Memory beat present |
| mem_rsp_data | input | 8 | Memory beat byte |

## Verification
The assertions assume that memory sends exactly four beats per fetch, in wrapped order, and sends no beat while no fetch is pending. They also assume that a beat never arrives in the same cycle as the fetch pulse. The bench's memory model answers each fetch only after a two-cycle delay, puts an idle cycle between the second and third beats, and is otherwise silent. The processor side drives a request only while req_ready is high. The bench predicts every returned byte from its own address-to-data function and predicts hit or miss from its own tag record.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  typedef enum logic {FILL_IDLE = 1'b0, FILL_BUSY = 1'b1} fill_state_e;
endpackage

// File: rtl/dm_tag_store.sv
module dm_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/dm_data_store.sv
module dm_data_store #(
  parameter int IDX_W = 8,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte
);
  localparam int LINES = 1 << IDX_W;
  localparam int LANES = 1 << OFF_W;

  logic [7:0] lane_rd [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_off == OFF_W'(l))) lane_q[wr_idx] <= wr_byte;
    end
    assign lane_rd[l] = lane_q[rd_idx];
  end

  assign rd_byte = lane_rd[rd_off];
endmodule

// File: rtl/dm_refill_ctrl.sv
module dm_refill_ctrl
  import dm_cache_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFF_W-1:0] start_off,
  input  logic             beat_in,
  output logic             busy,
  output logic             beat_we,
  output logic [OFF_W-1:0] beat_off,
  output logic             beat_first,
  output logic             beat_last
);
  fill_state_e      state_q;
  logic [OFF_W-1:0] cnt_q;
  logic [OFF_W-1:0] first_q;

  assign busy       = (state_q == FILL_BUSY);
  assign beat_we    = busy && beat_in;
  assign beat_off   = first_q + cnt_q;
  assign beat_first = beat_we && (cnt_q == '0);
  assign beat_last  = beat_we && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      cnt_q   <= '0;
      first_q <= '0;
    end else if (!busy) begin
      if (start) begin
        state_q <= FILL_BUSY;
        cnt_q   <= '0;
        first_q <= start_off;
      end
    end else if (beat_we) begin
      cnt_q <= cnt_q + 1'b1;
      if (beat_last) state_q <= FILL_IDLE;
    end
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [OFF_W-1:0]  mem_req_first,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [OFF_W-1:0] addr_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [ADDR_W-1:0] block_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  logic             busy, beat_we, beat_first, beat_last;
  logic [OFF_W-1:0] beat_off;
  logic [TAG_W-1:0] rd_tag;
  logic             rd_valid;
  logic [7:0]       rd_byte;
  logic [TAG_W-1:0] miss_tag_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic             accept, lookup_hit, lookup_miss;

  assign req_ready   = !busy;
  assign accept      = req_valid && req_ready;
  assign lookup_hit  = accept && rd_valid && (rd_tag == addr_tag(req_addr));
  assign lookup_miss = accept && !lookup_hit;

  dm_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(addr_idx(req_addr)), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .wr_en(beat_last), .wr_idx(miss_idx_q), .wr_tag(miss_tag_q)
  );

  dm_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk(clk),
    .wr_en(beat_we), .wr_idx(miss_idx_q), .wr_off(beat_off), .wr_byte(mem_rsp_data),
    .rd_idx(addr_idx(req_addr)), .rd_off(addr_off(req_addr)), .rd_byte(rd_byte)
  );

  dm_refill_ctrl #(.OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .start(lookup_miss), .start_off(addr_off(req_addr)), .beat_in(mem_rsp_valid),
    .busy(busy), .beat_we(beat_we), .beat_off(beat_off),
    .beat_first(beat_first), .beat_last(beat_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_first <= '0;
      miss_tag_q    <= '0;
      miss_idx_q    <= '0;
    end else begin
      rsp_valid     <= lookup_hit || beat_first;
      mem_req_valid <= lookup_miss;
      if (lookup_hit)      rsp_data <= rd_byte;
      else if (beat_first) rsp_data <= mem_rsp_data;
      if (lookup_miss) begin
        mem_req_addr  <= block_base(req_addr);
        mem_req_first <= addr_off(req_addr);
        miss_tag_q    <= addr_tag(req_addr);
        miss_idx_q    <= addr_idx(req_addr);
      end
    end
  end
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [OFF_W-1:0]  mem_req_first,
  input logic              mem_rsp_valid,
  input logic              lookup_hit,
  input logic              lookup_miss
);
  // R4
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> rsp_valid && !mem_req_valid);

  // R5
  miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_miss |=> mem_req_valid &&
      (mem_req_addr == {$past(req_addr[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}}));

  // R5
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R6
  miss_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_miss |=> mem_req_first == $past(req_addr[OFF_W-1:0]));

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R8
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(mem_rsp_valid));
endmodule

bind dm_cache dm_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_first(mem_req_first), .mem_rsp_valid(mem_rsp_valid),
  .lookup_hit(lookup_hit), .lookup_miss(lookup_miss)
);

// File: tb/tb_dm_cache.sv
module tb_dm_cache;
  localparam int AW = 24;
  localparam int IW = 8;
  localparam int OW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [7:0]    rsp_data;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [OW-1:0] mem_req_first;
  logic          mem_rsp_valid = 1'b0;
  logic [7:0]    mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int beats_started = 0;
  bit filling = 1'b0;

  logic [7:0]    exp_data_q [$];
  bit            exp_miss_q [$];
  logic [AW-1:0] exp_addr_q [$];
  logic [AW-1:0] miss_addr_q [$];

  bit            ref_valid [1 << IW];
  logic [AW-IW-OW-1:0] ref_tag [1 << IW];

  always #4 clk = ~clk;

  dm_cache #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_first(mem_req_first), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101} ^ (a[23:16] * 8'd13) ^ {a[15:13], 5'd0};
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: predicts hit or miss from its own tag record (R2, R3, R9)
  task automatic access(input logic [AW-1:0] a);
    logic [IW-1:0] idx;
    bit hit;
    idx = a[OW +: IW];
    while (!req_ready) @(negedge clk);
    hit = ref_valid[idx] && (ref_tag[idx] == a[AW-1 -: AW-IW-OW]);
    exp_data_q.push_back(mem_byte(a));
    exp_miss_q.push_back(!hit);
    exp_addr_q.push_back(a);
    if (!hit) begin
      miss_addr_q.push_back(a);
      ref_valid[idx] = 1'b1;
      ref_tag[idx] = a[AW-1 -: AW-IW-OW];
    end
    req_valid = 1'b1;
    req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model: wrapped beats, 2-cycle latency, idle gap after the second beat
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [AW-1:0] ea;
        logic [AW-1:0] blk;
        logic [OW-1:0] first;
        blk = mem_req_addr;
        first = mem_req_first;
        if (miss_addr_q.size() == 0) begin
          check("R4", 1'b0, "fetch issued on a hit", blk, 0);
        end else begin
          ea = miss_addr_q.pop_front();
          check("R5", blk == {ea[AW-1:OW], 2'b00}, "fetch address", blk, {ea[AW-1:OW], 2'b00});
          check("R6", first == ea[OW-1:0], "first beat offset", first, ea[OW-1:0]);
        end
        filling = 1'b1;
        beats_started = 0;
        repeat (2) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_byte({blk[AW-1:OW], 2'(first + 2'(b))});
          beats_started++;
          @(negedge clk);
          if (b < 3) check("R8", !req_ready, "ready during fill", req_ready, 0);
          if (b == 1) begin
            mem_rsp_valid = 1'b0;
            @(negedge clk);
          end
        end
        mem_rsp_valid = 1'b0;
        filling = 1'b0;
        check("R8", req_ready, "ready after last beat", req_ready, 1);
      end
    end
  end

  // monitor: scoreboard of returned bytes
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && rsp_valid) begin
        if (exp_data_q.size() == 0) begin
          check("R4", 1'b0, "unexpected response", rsp_data, 0);
        end else begin
          logic [7:0] ed;
          logic [AW-1:0] ea;
          bit em;
          ed = exp_data_q.pop_front();
          em = exp_miss_q.pop_front();
          ea = exp_addr_q.pop_front();
          if (em) begin
            check("R6", rsp_data == ed, "miss byte", rsp_data, ed);
            check("R7", filling && beats_started == 1, "early forward beats", beats_started, 1);
          end else begin
            check(ea[23] ? "R9" : "R4", rsp_data == ed, "hit byte", rsp_data, ed);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R1
    check("R1", req_ready == 1'b1, "ready in reset", req_ready, 1);
    check("R1", rsp_valid == 1'b0, "rsp_valid in reset", rsp_valid, 0);
    check("R1", mem_req_valid == 1'b0, "fetch in reset", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: first access misses; R6 offset 2 wraps 2,3,0,1
    access(24'h123456);
    access(24'h123454);
    access(24'h123455);
    access(24'h123457);
    access(24'h123456);
    // R2 / R9: same index, different tag evicts
    access(24'h9A3457);
    access(24'h9A3454);
    access(24'h123455);
    access(24'h9A3456);
    // offsets 0, 1, 3 as critical byte
    access(24'h000100);
    access(24'h000205);
    access(24'h00030B);
    access(24'h000101);
    r = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      access({r[6] ? 14'h01A5 : 14'h02C3, 4'h0, r[5:2], r[1:0]});
    end
    for (int i = 0; i < 40; i++) @(negedge clk);
    check("R4", exp_data_q.size() == 0, "responses outstanding", exp_data_q.size(), 0);
    check("R5", miss_addr_q.size() == 0, "fetches missing", miss_addr_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule